// File: doc/BRIEF.md
# Cache Slice Event Counter Unit

This block counts activity events produced by one cache slice. Eight 48-bit counters each pick one line of a 13-wide event-pulse vector through an 8-bit event code, and add one in every clock cycle where that line is high, the unit-wide run bit is set and the counter's own enable bit is set. When a counter wraps past its largest value it raises a sticky overflow flag. Unmasked flags drive a single level interrupt.

Software reaches every counter, every event-code word, the control word, the enable word, the interrupt mask, the flag word and a write-one-to-clear port through one register port. A write takes effect at the clock edge that samples it. A read is combinational from the address. Counter slots are 64 bits wide. All other registers use the low 32 data bits.

Top module: `evctr_unit`

## Requirements
- R1: After a synchronous reset, every counter, both event-code words, the enable word, the control word and the flag word read 0, the mask word reads 0xFF, and `irq` is low.
- R2: A counter adds exactly one at a clock edge where three conditions hold together: bit 17 of the control word at 0x0408 is set, the counter's bit in the enable word at 0x1C00 is set, and the event line selected by its code is high.
- R3: Event codes map to inputs as follows. Codes 0x00 to 0x04 select `evt_in[0]` to `evt_in[4]`. Codes 0x20 to 0x23 select `evt_in[5]` to `evt_in[8]`. Code 0x29 selects `evt_in[9]`. Codes 0x40 to 0x42 select `evt_in[10]` to `evt_in[12]`. Any other code, including 0xFF, never counts.
- R4: The code for counters 0 to 3 lives in the word at 0x1D00, and the code for counters 4 to 7 lives in the word at 0x1D04. Counter n uses bits 8*(n%4)+7 down to 8*(n%4) of its word.
- R5: Counter n is a 64-bit slot at 0x1E00 + 8*n. Bits 63:48 always read 0 and writes to them are dropped. A write loads bits 47:0, and no increment happens in that cycle.
- R6: An increment from 0xFFFF_FFFF_FFFF wraps the counter to 0 and sets bit n of the flag word at 0x0808. Counting then goes on from 0.
- R7: Writing 1 to bit n at 0x080C clears flag n. Zero bits leave their flags unchanged. A wrap in the same cycle keeps the flag set.
- R8: `irq` is high exactly when some flag is set whose bit in the mask word at 0x0800 is 0. A mask bit of 1 blocks that flag.
- R9: While bit 17 of the control word is clear, no counter changes except through a direct write. Other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 16 | Byte address of the register |
| reg_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| evt_in | input | 13 | Event pulse lines from the cache slice |
| irq | output | 1 | Level interrupt for unmasked overflow flags |

## Verification
The three kinds of result are due at different times:
- A write or an event pulse presented before a rising edge shows up in the counter, flag and register state right after that edge.
- `irq` follows the new flag and mask state in the same cycle, because it is combinational from those registers.
- Read data is valid within the same cycle that the address is presented.

The bench keeps to these timings as follows. It drives inputs at the falling edge and advances a behavioural model at each rising edge. It compares `irq` on every falling edge, and it samples `reg_rdata` shortly after setting an address on a falling edge. The wrap, the flag clear and the clear that meets a wrap are all arranged on back-to-back writes, so each one lands on a known edge.

// File: rtl/evctr_pkg.sv
`timescale 1ns/1ps
package evctr_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 64;
    localparam int REG_W       = 32;
    localparam int CODE_W      = 8;
    localparam int CODES_PER_W = REG_W / CODE_W;
    localparam int EVT_NUM     = 13;
    localparam int EVT_IDX_W   = $clog2(EVT_NUM);
    localparam int RUN_BIT     = 17;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 16'h0408;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 16'h0800;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_ENA   = 16'h1C00;
    localparam logic [ADDR_W-1:0] OFS_CODE  = 16'h1D00;
    localparam logic [ADDR_W-1:0] OFS_SLOT  = 16'h1E00;

    typedef enum logic [2:0] {
        RK_NONE, RK_CTRL, RK_IMASK, RK_FLAG, RK_CLR, RK_ENA, RK_CODE, RK_SLOT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] slot;
    } reg_dec_t;

    typedef struct packed {
        logic                 hit;
        logic [EVT_IDX_W-1:0] idx;
    } evt_route_t;

    function automatic reg_dec_t decode_addr(logic [ADDR_W-1:0] a, int num_ctr, int num_code);
        reg_dec_t          d;
        logic [ADDR_W-1:0] off;
        d.kind = RK_NONE;
        d.slot = '0;
        off    = '0;
        if (a == OFS_CTRL)       d.kind = RK_CTRL;
        else if (a == OFS_IMASK) d.kind = RK_IMASK;
        else if (a == OFS_FLAG)  d.kind = RK_FLAG;
        else if (a == OFS_CLR)   d.kind = RK_CLR;
        else if (a == OFS_ENA)   d.kind = RK_ENA;
        else if (a >= OFS_CODE && a < OFS_CODE + ADDR_W'(4 * num_code) && a[1:0] == 2'b00) begin
            off    = a - OFS_CODE;
            d.kind = RK_CODE;
            d.slot = off[9:2];
        end else if (a >= OFS_SLOT && a < OFS_SLOT + ADDR_W'(8 * num_ctr) && a[2:0] == 3'b000) begin
            off    = a - OFS_SLOT;
            d.kind = RK_SLOT;
            d.slot = off[10:3];
        end
        return d;
    endfunction

    function automatic evt_route_t route_code(logic [CODE_W-1:0] code);
        evt_route_t r;
        r.hit = 1'b1;
        r.idx = '0;
        if (code <= 8'h04)                        r.idx = EVT_IDX_W'(code);
        else if (code >= 8'h20 && code <= 8'h23)  r.idx = EVT_IDX_W'(code - 8'h20 + 8'd5);
        else if (code == 8'h29)                   r.idx = EVT_IDX_W'(9);
        else if (code >= 8'h40 && code <= 8'h42)  r.idx = EVT_IDX_W'(code - 8'h40 + 8'd10);
        else                                      r.hit = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/evctr_sel.sv
`timescale 1ns/1ps
module evctr_sel
    import evctr_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic [EVT_NUM-1:0] evt,
    output logic               pulse
);
    evt_route_t route;

    always_comb begin
        route = route_code(code);
        pulse = route.hit && evt[route.idx];
    end
endmodule

// File: rtl/evctr_cnt.sv
`timescale 1ns/1ps
module evctr_cnt #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign ovf = inc && !ld && (&cnt);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld) |=> $stable(cnt)); // R9
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val))); // R5
endmodule

// File: rtl/evctr_unit.sv
`timescale 1ns/1ps
module evctr_unit
    import evctr_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [15:0]        reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [12:0]        evt_in,
    output logic               irq
);
    localparam int NUM_CODE = (NUM_CTR + CODES_PER_W - 1) / CODES_PER_W;

    reg_dec_t           dec;
    logic               run_q;
    logic [NUM_CTR-1:0] ena_q, mask_q, flag_q;
    logic [REG_W-1:0]   code_q [NUM_CODE];
    logic [CTR_W-1:0]   cnt    [NUM_CTR];
    logic [NUM_CTR-1:0] hit, inc, ld, ovf, clr_bits;

    assign dec      = decode_addr(reg_addr, NUM_CTR, NUM_CODE);
    assign clr_bits = (reg_wr && dec.kind == RK_CLR) ? reg_wdata[NUM_CTR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            ena_q  <= '0;
            mask_q <= '1;
            flag_q <= '0;
        end else begin
            if (reg_wr && dec.kind == RK_CTRL)  run_q  <= reg_wdata[RUN_BIT];
            if (reg_wr && dec.kind == RK_ENA)   ena_q  <= reg_wdata[NUM_CTR-1:0];
            if (reg_wr && dec.kind == RK_IMASK) mask_q <= reg_wdata[NUM_CTR-1:0];
            flag_q <= (flag_q & ~clr_bits) | ovf;
        end
    end

    generate
        for (genvar s = 0; s < NUM_CODE; s++) begin : g_code
            always_ff @(posedge clk) begin
                if (rst)
                    code_q[s] <= '0;
                else if (reg_wr && dec.kind == RK_CODE && dec.slot == 8'(s))
                    code_q[s] <= reg_wdata[REG_W-1:0];
            end
        end

        for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
            evctr_sel u_sel (
                .code  (code_q[n / CODES_PER_W][CODE_W*(n % CODES_PER_W) +: CODE_W]),
                .evt   (evt_in),
                .pulse (hit[n])
            );

            assign inc[n] = run_q && ena_q[n] && hit[n];
            assign ld[n]  = reg_wr && dec.kind == RK_SLOT && dec.slot == 8'(n);

            evctr_cnt #(.W(CTR_W)) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .inc    (inc[n]),
                .ld     (ld[n]),
                .ld_val (reg_wdata[CTR_W-1:0]),
                .cnt    (cnt[n]),
                .ovf    (ovf[n])
            );

            AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
                ovf[n] |=> flag_q[n]); // R6
            AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
                (clr_bits[n] && !ovf[n]) |=> !flag_q[n]); // R7
            AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
                (flag_q[n] && !clr_bits[n]) |=> flag_q[n]); // R7
        end
    endgenerate

    assign irq = |(flag_q & ~mask_q);

    always_comb begin
        reg_rdata = '0;
        case (dec.kind)
            RK_CTRL:  reg_rdata[RUN_BIT]     = run_q;
            RK_IMASK: reg_rdata[NUM_CTR-1:0] = mask_q;
            RK_FLAG:  reg_rdata[NUM_CTR-1:0] = flag_q;
            RK_ENA:   reg_rdata[NUM_CTR-1:0] = ena_q;
            RK_CODE: begin
                for (int s = 0; s < NUM_CODE; s++)
                    if (dec.slot == 8'(s)) reg_rdata[REG_W-1:0] = code_q[s];
            end
            RK_SLOT: begin
                for (int n = 0; n < NUM_CTR; n++)
                    if (dec.slot == 8'(n)) reg_rdata[CTR_W-1:0] = cnt[n];
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq); // R8
    AST_SLOT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == RK_SLOT) |-> (reg_rdata[DATA_W-1:CTR_W] == '0)); // R5
endmodule

// File: tb/test_evctr_unit.sv
`timescale 1ns/1ps
module test_evctr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [12:0] evt_in = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    evctr_unit i_evctr_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
    );

    // behavioural reference model
    logic [47:0] m_cnt [8];
    logic [31:0] m_code [2];
    logic        m_run;
    logic [7:0]  m_ena, m_mask, m_flag;

    function automatic int m_route(logic [7:0] c);
        case (c)
            8'h00: return 0;  8'h01: return 1;  8'h02: return 2;
            8'h03: return 3;  8'h04: return 4;  8'h20: return 5;
            8'h21: return 6;  8'h22: return 7;  8'h23: return 8;
            8'h29: return 9;  8'h40: return 10; 8'h41: return 11;
            8'h42: return 12;
            default: return -1;
        endcase
    endfunction

    function automatic logic [63:0] m_read(logic [15:0] a);
        logic [63:0] v;
        v = '0;
        case (a)
            16'h0408: v[17]  = m_run;
            16'h0800: v[7:0] = m_mask;
            16'h0808: v[7:0] = m_flag;
            16'h1C00: v[7:0] = m_ena;
            16'h1D00: v[31:0] = m_code[0];
            16'h1D04: v[31:0] = m_code[1];
            default: begin
                for (int n = 0; n < 8; n++)
                    if (a == 16'h1E00 + 16'(8 * n)) v[47:0] = m_cnt[n];
            end
        endcase
        return v;
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] ovf, clr;
        int k;
        if (rst) begin
            for (int n = 0; n < 8; n++) m_cnt[n] = '0;
            m_code[0] = '0; m_code[1] = '0;
            m_run = 1'b0; m_ena = '0; m_mask = 8'hFF; m_flag = '0;
        end else begin
            ovf = '0;
            clr = '0;
            for (int n = 0; n < 8; n++) begin
                k = m_route(m_code[n / 4][8 * (n % 4) +: 8]);
                if (reg_wr && reg_addr == 16'h1E00 + 16'(8 * n))
                    m_cnt[n] = reg_wdata[47:0];
                else if (m_run && m_ena[n] && k >= 0 && evt_in[k]) begin
                    if (m_cnt[n] == 48'hFFFF_FFFF_FFFF) ovf[n] = 1'b1;
                    m_cnt[n] = m_cnt[n] + 48'd1;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    16'h0408: m_run = reg_wdata[17];
                    16'h0800: m_mask = reg_wdata[7:0];
                    16'h080C: clr = reg_wdata[7:0];
                    16'h1C00: m_ena = reg_wdata[7:0];
                    16'h1D00: m_code[0] = reg_wdata[31:0];
                    16'h1D04: m_code[1] = reg_wdata[31:0];
                    default: ;
                endcase
            end
            m_flag = (m_flag & ~clr) | ovf;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: interrupt level compared every cycle against the model
    always @(negedge clk) begin
        if (!rst && !done)
            check(irq === |(m_flag & ~m_mask), "R8", 64'(irq), 64'(|(m_flag & ~m_mask)));
    end

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #0.5 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #0.5 check(reg_rdata === m_read(a), req, reg_rdata, m_read(a));
    endtask

    task automatic run_rand(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            evt_in = lfsr[12:0];
        end
    endtask

    task automatic rd_all_slots(input string req);
        for (int n = 0; n < 8; n++) rd(16'h1E00 + 16'(8 * n), req);
    endtask

    task automatic finish_test;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(16'h0408, "R1"); rd(16'h0800, "R1"); rd(16'h0808, "R1");
        rd(16'h1C00, "R1"); rd(16'h1D00, "R1"); rd(16'h1D04, "R1");
        rd_all_slots("R1");
        check(irq === 1'b0, "R1", 64'(irq), 64'd0);

        // R4 packing, R3 codes (0xFF and 0x05 count nothing)
        wr(16'h1D00, 64'h0000_0000_FF29_0300);
        wr(16'h1D04, 64'h0000_0000_4005_2042);
        wr(16'h1C00, 64'hFF);
        rd(16'h1D00, "R4"); rd(16'h1D04, "R4");
        // R9 run bit clear: nothing counts
        @(negedge clk) evt_in = '1;
        repeat (6) @(negedge clk);
        rd_all_slots("R9");
        check(m_read(16'h1E00) == 64'd0, "R9", m_read(16'h1E00), 64'd0);

        // R2 / R3 / R4 random event traffic
        wr(16'h0408, 64'h0002_0000);
        rd(16'h0408, "R9");
        run_rand(60);
        rd_all_slots("R3");
        // per-counter enable
        wr(16'h1C00, 64'hFD);
        run_rand(40);
        rd_all_slots("R2");
        // remap with other codes
        wr(16'h1D00, 64'h0000_0000_4122_2104);
        wr(16'h1D04, 64'h0000_0000_2300_0201);
        wr(16'h1C00, 64'hFF);
        run_rand(50);
        rd_all_slots("R4");

        // R5 slot width and load
        @(negedge clk) evt_in = 13'h0001;
        wr(16'h1D00, 64'h0000_0000_FFFF_FF00);
        wr(16'h1D04, 64'h0000_0000_FFFF_FFFF);
        wr(16'h1E00, 64'hABCD_FFFF_FFFF_FFFD);
        rd(16'h1E00, "R5");
        check(reg_rdata[63:48] === 16'h0, "R5", {48'd0, reg_rdata[63:48]}, 64'd0);
        // R6 wrap sets flag, still masked so irq low
        repeat (4) @(negedge clk);
        rd(16'h0808, "R6");
        check(m_flag[0] == 1'b1, "R6", 64'(m_flag), 64'd1);
        rd(16'h1E00, "R6");
        // R8 unmask
        wr(16'h0800, 64'hFE);
        @(negedge clk);
        check(irq === 1'b1, "R8", 64'(irq), 64'd1);
        // R7 zeros do nothing, ones clear
        wr(16'h080C, 64'h00);
        rd(16'h0808, "R7");
        wr(16'h080C, 64'h01);
        rd(16'h0808, "R7");
        check(reg_rdata[0] === 1'b0, "R7", reg_rdata, 64'd0);
        // R7 clear meets wrap in the same cycle: flag stays set
        wr(16'h1E00, 64'h0000_FFFF_FFFF_FFFF);
        wr(16'h080C, 64'h01);
        rd(16'h0808, "R7");
        check(reg_rdata[0] === 1'b1, "R7", reg_rdata, 64'd1);
        wr(16'h0800, 64'hFF);
        rd(16'h0800, "R8");
        repeat (3) @(negedge clk);
        finish_test();
    end
endmodule